// File: doc/BRIEF.md
# Update-Based Coherent Cache Controller

This block runs a small direct-mapped write-back cache that stays coherent with its peers on a snooping bus. It keeps copies in step by broadcasting rather than invalidating. When the processor writes a line that other caches may also hold, the controller puts that one word, with its offset inside the block, on the bus as an update transaction. Peer caches patch their copies. A wired shared line tells the writer whether anyone still holds the block.

A line that is present is always in one of four states: exclusive clean, shared clean, shared owned (dirty, with copies elsewhere) and modified (dirty, sole copy). A line that is not present has no state. Only an owner, in shared-owned or modified state, supplies the block on a snooped read. Only an owner writes the block back to memory when it is evicted. The memory and the bus arbiter sit outside the block. The bus port raises a request that stays up until the bus signals completion. On that completion cycle the bus also returns the fill data and the sampled shared line.

Top module: `dragon_cache_ctrl`

## Requirements
- R1: After reset every line is not present. `mst_valid`, `cpu_done`, `snp_shared` and `snp_flush` are low, and `mst_cmd` is 0 whenever `mst_valid` is low.
- R2: A read miss issues a bus read (`mst_cmd`=1) for the block address {tag,index}. The requested word goes to `cpu_rdata`. The line becomes exclusive clean if `mst_shared` was low at completion, and shared clean otherwise.
- R3: A read hit makes no bus request. `cpu_done` is high for exactly one cycle, the cycle after the request is accepted, with the word on `cpu_rdata`.
- R4: A write to an exclusive clean line makes no bus request, and the line becomes modified.
- R5: A write to a shared clean or shared owned line issues an update (`mst_cmd`=2) carrying the block address, the word offset `mst_off` and the word `mst_word`. The line ends shared owned if `mst_shared` is high at completion, and modified otherwise.
- R6: A write miss issues a bus read. If `mst_shared` is low at completion, the line becomes modified and no update follows. If it is high, an update follows at once and its own shared result picks shared owned or modified as in R5. The written word is merged into the filled block.
- R7: A snooped update (`snp_cmd`=2) to a resident line writes `snp_word` at `snp_off`, and the line becomes shared clean. A shared owned line therefore gives up ownership.
- R8: A snooped read (`snp_cmd`=1) to a modified line raises `snp_flush` with the block on `snp_fline`, and the line becomes shared owned. A shared owned line also flushes and keeps its state. An exclusive clean line becomes shared clean, and clean lines never flush.
- R9: `snp_shared` is high in the same cycle as any snooped command whose block is resident, and low otherwise.
- R10: A miss that evicts a modified or shared owned line first issues a write-back (`mst_cmd`=3) of the old block address with the line on `mst_wline`, then the bus read. Evicting a clean line issues only the read.
- R11: A processor request is not accepted in a cycle where `snp_valid` is high, so a snoop always takes effect before a competing processor access.
- R12: While `mst_valid` is high and `mst_done` has not arrived, `mst_cmd` and `mst_blk` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag,index,offset} |
| cpu_wdata | input | DW | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with `cpu_done` on reads |
| mst_valid | output | 1 | Bus request active |
| mst_cmd | output | 2 | 0 idle, 1 read, 2 update, 3 write-back |
| mst_blk | output | ADDR_W-OFF_W | Block address of the request |
| mst_off | output | OFF_W | Word offset for updates |
| mst_word | output | DW | Word carried by an update |
| mst_wline | output | LINE_W | Block carried by a write-back |
| mst_done | input | 1 | Bus completion of the current request |
| mst_shared | input | 1 | Shared line sampled at completion |
| mst_rline | input | LINE_W | Fill block returned with a read completion |
| snp_valid | input | 1 | Another agent's command is on the bus |
| snp_cmd | input | 2 | 1 read, 2 update |
| snp_blk | input | ADDR_W-OFF_W | Snooped block address |
| snp_off | input | OFF_W | Snooped update word offset |
| snp_word | input | DW | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped block |
| snp_flush | output | 1 | This cache supplies the block |
| snp_fline | output | LINE_W | Supplied block, zero when not flushing |

## Verification
The hardest state to reach is an owner that loses ownership. A line has to be pulled into shared owned first, either by a write to a shared copy that still sees the shared line high or by a snooped read hitting a modified line. Only then can a peer update demote it. The bench plays every peer through the snoop port and picks the shared response per transaction, so it can walk one line through exclusive, shared clean, shared owned and back to shared clean. Each step shows only in the flush and shared responses and in whether the next write goes on the bus. The bench also evicts a shared owned line so that its write-back can be observed before the fill.

// File: rtl/dragon_pkg.sv
package dragon_pkg;
   typedef enum logic [2:0] {
      LS_NP  = 3'd0,
      LS_EXC = 3'd1,
      LS_SHC = 3'd2,
      LS_SHM = 3'd3,
      LS_MOD = 3'd4
   } line_st_t;

   typedef enum logic [1:0] {
      BC_IDLE = 2'd0,
      BC_READ = 2'd1,
      BC_UPD  = 2'd2,
      BC_WB   = 2'd3
   } bus_cmd_t;

   localparam int ST_W = $bits(line_st_t);
endpackage

// File: rtl/cc_state_store.sv
module cc_state_store
   import dragon_pkg::*;
#(
   parameter  int SETS  = 4,
   parameter  int TAG_W = 6,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  line_st_t         wst,
   input  logic [TAG_W-1:0] wtag,
   input  logic [IDX_W-1:0] ridx_a,
   output line_st_t         rst_a,
   output logic [TAG_W-1:0] rtag_a,
   input  logic [IDX_W-1:0] ridx_b,
   output line_st_t         rst_b,
   output logic [TAG_W-1:0] rtag_b
);
   logic [SETS*ST_W-1:0]  st_flat;
   logic [SETS*TAG_W-1:0] tag_flat;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      line_st_t         st_q;
      logic [TAG_W-1:0] tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= LS_NP;
            tag_q <= '0;
         end else if (we && widx == IDX_W'(s)) begin
            st_q  <= wst;
            tag_q <= wtag;
         end
      end
      assign st_flat[s*ST_W +: ST_W]    = st_q;
      assign tag_flat[s*TAG_W +: TAG_W] = tag_q;
   end

   assign rst_a  = line_st_t'(st_flat[int'(ridx_a)*ST_W +: ST_W]);
   assign rtag_a = tag_flat[int'(ridx_a)*TAG_W +: TAG_W];
   assign rst_b  = line_st_t'(st_flat[int'(ridx_b)*ST_W +: ST_W]);
   assign rtag_b = tag_flat[int'(ridx_b)*TAG_W +: TAG_W];
endmodule

// File: rtl/cc_data_store.sv
module cc_data_store #(
   parameter  int SETS   = 4,
   parameter  int WORDS  = 4,
   parameter  int DW     = 16,
   localparam int IDX_W  = $clog2(SETS),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = WORDS*DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_we,
   input  logic              word_we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [OFF_W-1:0]  woff,
   input  logic [LINE_W-1:0] wline,
   input  logic [DW-1:0]     wword,
   input  logic [IDX_W-1:0]  ridx_a,
   output logic [LINE_W-1:0] rline_a,
   input  logic [IDX_W-1:0]  ridx_b,
   output logic [LINE_W-1:0] rline_b
);
   logic [SETS*LINE_W-1:0] data_flat;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         logic [DW-1:0] w_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               w_q <= '0;
            end else if (blk_we && widx == IDX_W'(s)) begin
               w_q <= wline[w*DW +: DW];
            end else if (word_we && widx == IDX_W'(s) && woff == OFF_W'(w)) begin
               w_q <= wword;
            end
         end
         assign data_flat[s*LINE_W + w*DW +: DW] = w_q;
      end
   end

   assign rline_a = data_flat[int'(ridx_a)*LINE_W +: LINE_W];
   assign rline_b = data_flat[int'(ridx_b)*LINE_W +: LINE_W];
endmodule

// File: rtl/cc_snoop.sv
module cc_snoop
   import dragon_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_t         cur_st,
   input  logic [TAG_W-1:0] cur_tag,
   output logic             hit,
   output logic             flush,
   output logic             st_we,
   output line_st_t         st_new,
   output logic             word_we
);
   always_comb begin
      hit     = snp_valid && (cur_st != LS_NP) && (cur_tag == snp_tag);
      flush   = hit && (snp_cmd == BC_READ) && ((cur_st == LS_MOD) || (cur_st == LS_SHM));
      st_we   = 1'b0;
      st_new  = cur_st;
      word_we = 1'b0;
      if (hit) begin
         case (snp_cmd)
            BC_READ: begin
               if (cur_st == LS_MOD) begin
                  st_we  = 1'b1;
                  st_new = LS_SHM;
               end else if (cur_st == LS_EXC) begin
                  st_we  = 1'b1;
                  st_new = LS_SHC;
               end
            end
            BC_UPD: begin
               word_we = 1'b1;
               st_we   = 1'b1;
               st_new  = LS_SHC;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
   import dragon_pkg::*;
#(
   parameter  int ADDR_W = 10,
   parameter  int WORDS  = 4,
   parameter  int DW     = 16,
   parameter  int SETS   = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int IDX_W  = $clog2(SETS),
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
   localparam int BLK_W  = ADDR_W - OFF_W,
   localparam int LINE_W = WORDS*DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   output logic              cpu_done,
   output logic [DW-1:0]     cpu_rdata,
   input  logic              snp_busy,
   output logic [IDX_W-1:0]  lk_idx,
   input  line_st_t          look_st,
   input  logic [TAG_W-1:0]  look_tag,
   input  logic [LINE_W-1:0] look_line,
   output logic              mst_valid,
   output logic [1:0]        mst_cmd,
   output logic [BLK_W-1:0]  mst_blk,
   output logic [OFF_W-1:0]  mst_off,
   output logic [DW-1:0]     mst_word,
   output logic [LINE_W-1:0] mst_wline,
   input  logic              mst_done,
   input  logic              mst_shared,
   input  logic [LINE_W-1:0] mst_rline,
   output logic              st_we,
   output line_st_t          st_new,
   output logic [TAG_W-1:0]  st_tag,
   output logic              d_blk_we,
   output logic              d_word_we,
   output logic [OFF_W-1:0]  d_off,
   output logic [LINE_W-1:0] d_line,
   output logic [DW-1:0]     d_word
);
   typedef enum logic [2:0] {C_IDLE, C_WB, C_FILL, C_UPD, C_RESP} fsm_t;

   fsm_t              fsm_q, fsm_d;
   logic [ADDR_W-1:0] a_q;
   logic              we_q;
   logic [DW-1:0]     wd_q;
   logic [DW-1:0]     rd_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [TAG_W-1:0]  c_tag;
   logic [OFF_W-1:0]  c_off;
   logic              hit, accept, owner;

   assign cur_addr = (fsm_q == C_IDLE) ? cpu_addr : a_q;
   assign lk_idx   = cur_addr[OFF_W +: IDX_W];
   assign c_tag    = cur_addr[ADDR_W-1 -: TAG_W];
   assign c_off    = cur_addr[OFF_W-1:0];
   assign hit      = (look_st != LS_NP) && (look_tag == c_tag);
   assign owner    = (look_st == LS_SHM) || (look_st == LS_MOD);
   assign accept   = (fsm_q == C_IDLE) && cpu_req && !snp_busy;

   always_comb begin
      fsm_d     = fsm_q;
      st_we     = 1'b0;
      st_new    = look_st;
      st_tag    = c_tag;
      d_blk_we  = 1'b0;
      d_word_we = 1'b0;
      d_off     = c_off;
      d_word    = (fsm_q == C_IDLE) ? cpu_wdata : wd_q;
      d_line    = mst_rline;
      if (we_q) d_line[int'(c_off)*DW +: DW] = wd_q;
      case (fsm_q)
         C_IDLE: begin
            if (accept) begin
               if (hit) begin
                  if (!cpu_we) begin
                     fsm_d = C_RESP;
                  end else if (look_st == LS_EXC || look_st == LS_MOD) begin
                     d_word_we = 1'b1;
                     st_we     = 1'b1;
                     st_new    = LS_MOD;
                     fsm_d     = C_RESP;
                  end else begin
                     fsm_d = C_UPD;
                  end
               end else begin
                  fsm_d = owner ? C_WB : C_FILL;
               end
            end
         end
         C_WB: begin
            if (mst_done) fsm_d = C_FILL;
         end
         C_FILL: begin
            if (mst_done) begin
               d_blk_we = 1'b1;
               st_we    = 1'b1;
               if (!we_q) begin
                  st_new = mst_shared ? LS_SHC : LS_EXC;
                  fsm_d  = C_RESP;
               end else if (mst_shared) begin
                  st_new = LS_SHC;
                  fsm_d  = C_UPD;
               end else begin
                  st_new = LS_MOD;
                  fsm_d  = C_RESP;
               end
            end
         end
         C_UPD: begin
            if (mst_done) begin
               d_word_we = 1'b1;
               st_we     = 1'b1;
               st_new    = mst_shared ? LS_SHM : LS_MOD;
               fsm_d     = C_RESP;
            end
         end
         C_RESP: fsm_d = C_IDLE;
         default: fsm_d = C_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q <= C_IDLE;
         a_q   <= '0;
         we_q  <= 1'b0;
         wd_q  <= '0;
         rd_q  <= '0;
      end else begin
         fsm_q <= fsm_d;
         if (accept) begin
            a_q  <= cpu_addr;
            we_q <= cpu_we;
            wd_q <= cpu_wdata;
            if (hit && !cpu_we) rd_q <= look_line[int'(c_off)*DW +: DW];
         end
         if (fsm_q == C_FILL && mst_done && !we_q)
            rd_q <= mst_rline[int'(c_off)*DW +: DW];
      end
   end

   assign cpu_done  = (fsm_q == C_RESP);
   assign cpu_rdata = rd_q;
   assign mst_valid = (fsm_q == C_WB) || (fsm_q == C_FILL) || (fsm_q == C_UPD);
   assign mst_cmd   = (fsm_q == C_WB)   ? BC_WB   :
                      (fsm_q == C_FILL) ? BC_READ :
                      (fsm_q == C_UPD)  ? BC_UPD  : BC_IDLE;
   assign mst_blk   = (fsm_q == C_WB) ? {look_tag, lk_idx} : {c_tag, lk_idx};
   assign mst_off   = c_off;
   assign mst_word  = wd_q;
   assign mst_wline = look_line;

   // R12: the request is held until the bus completes it
   a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_valid && !mst_done) |=> (mst_valid && $stable(mst_cmd) && $stable(mst_blk)));

   // R3: completion is a single-cycle pulse
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R10: a finished write-back is followed at once by the fill read
   a_r10_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_valid && mst_cmd == BC_WB && mst_done) |=> (mst_valid && mst_cmd == BC_READ));
endmodule

// File: rtl/dragon_cache_ctrl.sv
module dragon_cache_ctrl
   import dragon_pkg::*;
#(
   parameter  int ADDR_W = 10,
   parameter  int WORDS  = 4,
   parameter  int DW     = 16,
   parameter  int SETS   = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int IDX_W  = $clog2(SETS),
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
   localparam int BLK_W  = ADDR_W - OFF_W,
   localparam int LINE_W = WORDS*DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   output logic              cpu_done,
   output logic [DW-1:0]     cpu_rdata,
   output logic              mst_valid,
   output logic [1:0]        mst_cmd,
   output logic [BLK_W-1:0]  mst_blk,
   output logic [OFF_W-1:0]  mst_off,
   output logic [DW-1:0]     mst_word,
   output logic [LINE_W-1:0] mst_wline,
   input  logic              mst_done,
   input  logic              mst_shared,
   input  logic [LINE_W-1:0] mst_rline,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [BLK_W-1:0]  snp_blk,
   input  logic [OFF_W-1:0]  snp_off,
   input  logic [DW-1:0]     snp_word,
   output logic              snp_shared,
   output logic              snp_flush,
   output logic [LINE_W-1:0] snp_fline
);
   initial begin
      assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0)
         else $error("WORDS must be a power of two of at least 2");
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0)
         else $error("SETS must be a power of two of at least 2");
      assert (TAG_W >= 1)
         else $error("ADDR_W too narrow for SETS and WORDS");
   end

   logic [IDX_W-1:0]  lk_idx, s_idx;
   logic [TAG_W-1:0]  s_tag, look_tag, snp_cur_tag, ctl_tag;
   line_st_t          look_st, snp_cur_st, ctl_st_new, snp_st_new, ss_wst;
   logic [LINE_W-1:0] look_line, snp_line, ctl_line;
   logic              ctl_st_we, snp_st_we, ctl_blk_we, ctl_word_we, snp_word_we;
   logic [OFF_W-1:0]  ctl_off;
   logic [DW-1:0]     ctl_word;
   logic              s_hit;

   assign s_idx = snp_blk[IDX_W-1:0];
   assign s_tag = snp_blk[BLK_W-1 -: TAG_W];

   cc_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .DW(DW), .SETS(SETS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .snp_busy(snp_valid),
      .lk_idx(lk_idx), .look_st(look_st), .look_tag(look_tag), .look_line(look_line),
      .mst_valid(mst_valid), .mst_cmd(mst_cmd), .mst_blk(mst_blk), .mst_off(mst_off),
      .mst_word(mst_word), .mst_wline(mst_wline), .mst_done(mst_done),
      .mst_shared(mst_shared), .mst_rline(mst_rline),
      .st_we(ctl_st_we), .st_new(ctl_st_new), .st_tag(ctl_tag),
      .d_blk_we(ctl_blk_we), .d_word_we(ctl_word_we), .d_off(ctl_off),
      .d_line(ctl_line), .d_word(ctl_word)
   );

   cc_snoop #(.TAG_W(TAG_W)) u_snoop (
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(s_tag),
      .cur_st(snp_cur_st), .cur_tag(snp_cur_tag),
      .hit(s_hit), .flush(snp_flush), .st_we(snp_st_we), .st_new(snp_st_new),
      .word_we(snp_word_we)
   );

   assign ss_wst = snp_st_we ? snp_st_new : ctl_st_new;

   cc_state_store #(.SETS(SETS), .TAG_W(TAG_W)) u_state (
      .clk(clk), .rst_n(rst_n),
      .we(snp_st_we | ctl_st_we),
      .widx(snp_st_we ? s_idx : lk_idx),
      .wst(ss_wst),
      .wtag(snp_st_we ? s_tag : ctl_tag),
      .ridx_a(lk_idx), .rst_a(look_st), .rtag_a(look_tag),
      .ridx_b(s_idx), .rst_b(snp_cur_st), .rtag_b(snp_cur_tag)
   );

   cc_data_store #(.SETS(SETS), .WORDS(WORDS), .DW(DW)) u_data (
      .clk(clk), .rst_n(rst_n),
      .blk_we(ctl_blk_we),
      .word_we(snp_word_we | ctl_word_we),
      .widx(snp_word_we ? s_idx : lk_idx),
      .woff(snp_word_we ? snp_off : ctl_off),
      .wline(ctl_line),
      .wword(snp_word_we ? snp_word : ctl_word),
      .ridx_a(lk_idx), .rline_a(look_line),
      .ridx_b(s_idx), .rline_b(snp_line)
   );

   assign snp_shared = s_hit;
   assign snp_fline  = snp_flush ? snp_line : '0;

   // R11: the snooper and the controller never write line state together
   a_r11_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_st_we, snp_st_we}));

   // R11: a snoop cycle delays acceptance, so no completion follows it directly
   a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !mst_valid && !cpu_done) |=> !cpu_done);

   // R8: only a holder of the block may supply it
   a_r8_flush_holder: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> snp_shared);

   // R9: with no snooped command the shared line stays low
   a_r9_quiet_shared: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid |-> (!snp_shared && !snp_flush));
endmodule

// File: tb/dragon_cache_ctrl_test.sv
module dragon_cache_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 10, WORDS = 4, DW = 16, SETS = 4;
   localparam int OFF_W = 2, IDX_W = 2, TAG_W = 6, BLK_W = 8, LINE_W = 64;

   logic clk = 0, rst_n = 0;
   logic cpu_req = 0, cpu_we = 0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic mst_valid;
   logic [1:0] mst_cmd;
   logic [BLK_W-1:0] mst_blk;
   logic [OFF_W-1:0] mst_off;
   logic [DW-1:0] mst_word;
   logic [LINE_W-1:0] mst_wline;
   logic mst_done = 0, mst_shared = 0;
   logic [LINE_W-1:0] mst_rline = '0;
   logic snp_valid = 0;
   logic [1:0] snp_cmd = 0;
   logic [BLK_W-1:0] snp_blk = '0;
   logic [OFF_W-1:0] snp_off = '0;
   logic [DW-1:0] snp_word = '0;
   logic snp_shared, snp_flush;
   logic [LINE_W-1:0] snp_fline;

   dragon_cache_ctrl uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, cycles = 0;
   bit sh_resp = 0;

   // reference model: 0 absent, 1 exclusive, 2 shared clean, 3 shared owned, 4 modified
   int m_st[SETS], m_tag[SETS];
   logic [LINE_W-1:0] m_line[SETS];
   logic [LINE_W-1:0] mem [int];
   int ec[$], eb[$], eo[$], ew[$];
   logic [LINE_W-1:0] el[$];
   int lc[$], lb[$], lo[$], lw[$];
   logic [LINE_W-1:0] ll[$];

   task automatic chk(bit ok, string rq, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic [LINE_W-1:0] mem_get(int b);
      logic [LINE_W-1:0] r;
      if (mem.exists(b)) return mem[b];
      for (int w = 0; w < WORDS; w++) r[w*DW +: DW] = 16'(16'h1000 + b*16 + w);
      return r;
   endfunction

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         finish_run();
      end
   end

   // per-clock comparison of the idle bus and snoop outputs
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (!snp_valid) chk(!snp_shared && !snp_flush, "R9 quiet", {snp_shared, snp_flush}, 0);
         if (!mst_valid) chk(mst_cmd == 0, "R1 idle cmd", mst_cmd, 0);
      end
   end

   // memory responder
   int rcnt = 0;
   logic [1:0] h_cmd;
   logic [BLK_W-1:0] h_blk;
   always @(negedge clk) begin
      if (mst_done) begin
         mst_done = 0; rcnt = 0;
      end else if (rst_n && mst_valid) begin
         rcnt++;
         if (rcnt == 1) begin h_cmd = mst_cmd; h_blk = mst_blk; end
         if (rcnt == 2) begin
            chk(mst_cmd == h_cmd && mst_blk == h_blk, "R12 hold", {mst_cmd, mst_blk}, {h_cmd, h_blk});
            mst_done = 1; mst_shared = sh_resp;
            mst_rline = mem_get(int'(mst_blk));
            lc.push_back(int'(mst_cmd)); lb.push_back(int'(mst_blk));
            lo.push_back(int'(mst_off)); lw.push_back(int'(mst_word)); ll.push_back(mst_wline);
            if (mst_cmd == 2'd3) mem[int'(mst_blk)] = mst_wline;
         end
      end
   end

   task automatic cpu_op(bit we, int addr, int wd, bit sh, string rq);
      int idx = (addr >> 2) & 3, tg = addr >> 4, off = addr & 3, blk = addr >> 2;
      bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
      logic [DW-1:0] exp_rd;
      int n;
      ec.delete(); eb.delete(); eo.delete(); ew.delete(); el.delete();
      lc.delete(); lb.delete(); lo.delete(); lw.delete(); ll.delete();
      if (!hit) begin
         if (m_st[idx] >= 3) begin
            ec.push_back(3); eb.push_back(m_tag[idx]*4 + idx); eo.push_back(0); ew.push_back(0);
            el.push_back(m_line[idx]);
         end
         ec.push_back(1); eb.push_back(blk); eo.push_back(0); ew.push_back(0); el.push_back('0);
         if (we && sh) begin
            ec.push_back(2); eb.push_back(blk); eo.push_back(off); ew.push_back(wd); el.push_back('0);
         end
         exp_rd = mem_get(blk)[off*DW +: DW];
      end else begin
         if (we && (m_st[idx] == 2 || m_st[idx] == 3)) begin
            ec.push_back(2); eb.push_back(blk); eo.push_back(off); ew.push_back(wd); el.push_back('0);
         end
         exp_rd = m_line[idx][off*DW +: DW];
      end
      sh_resp = sh;
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = DW'(wd);
      n = 0;
      do begin @(negedge clk); n++; end while (!cpu_done && n < 100);
      chk(cpu_done, {rq, " done"}, cpu_done, 1);
      if (!we) chk(cpu_rdata == exp_rd, {rq, " rdata"}, cpu_rdata, exp_rd);
      cpu_req = 0;
      chk(lc.size() == ec.size(), {rq, " bus count"}, lc.size(), ec.size());
      for (int i = 0; i < ec.size() && i < lc.size(); i++) begin
         chk(lc[i] == ec[i] && lb[i] == eb[i], {rq, " bus cmd/blk"}, {lc[i], lb[i]}, {ec[i], eb[i]});
         if (ec[i] == 2) chk(lo[i] == eo[i] && lw[i] == ew[i], {rq, " update word"}, {lo[i], lw[i]}, {eo[i], ew[i]});
         if (ec[i] == 3) chk(ll[i] == el[i], {rq, " write-back line"}, ll[i], el[i]);
      end
      if (!hit) begin
         m_line[idx] = mem_get(blk); m_tag[idx] = tg;
         if (!we) m_st[idx] = sh ? 2 : 1;
         else begin m_line[idx][off*DW +: DW] = DW'(wd); m_st[idx] = sh ? 3 : 4; end
      end else if (we) begin
         m_line[idx][off*DW +: DW] = DW'(wd);
         if (m_st[idx] == 1 || m_st[idx] == 4) m_st[idx] = 4;
         else m_st[idx] = sh ? 3 : 4;
      end
   endtask

   task automatic snoop(int cmd, int blk, int off, int wd, string rq);
      int idx = blk & 3, tg = blk >> 2;
      bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
      bit fl = hit && cmd == 1 && m_st[idx] >= 3;
      @(negedge clk);
      snp_valid = 1; snp_cmd = 2'(cmd); snp_blk = BLK_W'(blk); snp_off = OFF_W'(off); snp_word = DW'(wd);
      #1;
      chk(snp_shared == hit, {rq, " shared"}, snp_shared, hit);
      chk(snp_flush == fl, {rq, " flush"}, snp_flush, fl);
      if (fl) chk(snp_fline == m_line[idx], {rq, " flush data"}, snp_fline, m_line[idx]);
      @(negedge clk);
      snp_valid = 0;
      if (hit) begin
         if (cmd == 1) begin
            if (m_st[idx] == 4) m_st[idx] = 3;
            else if (m_st[idx] == 1) m_st[idx] = 2;
         end else begin
            m_line[idx][off*DW +: DW] = DW'(wd); m_st[idx] = 2;
         end
      end
   endtask

   function automatic int mk(int tg, int idx, int off);
      return tg*16 + idx*4 + off;
   endfunction

   initial begin
      for (int s = 0; s < SETS; s++) begin m_st[s] = 0; m_tag[s] = 0; m_line[s] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!mst_valid && !cpu_done && !snp_shared && !snp_flush, "R1 reset outputs",
          {mst_valid, cpu_done, snp_shared, snp_flush}, 0);
      snoop(1, 4, 0, 0, "R1 empty after reset");
      // R2: read miss, not shared then shared
      cpu_op(0, mk(1,0,2), 0, 0, "R2 read miss exclusive");
      cpu_op(0, mk(1,2,1), 0, 1, "R2 read miss shared");
      snoop(1, 1*4+2, 0, 0, "R2 shared clean no flush");
      // R3: read hit
      cpu_op(0, mk(1,0,2), 0, 0, "R3 read hit");
      // R8: exclusive to shared clean on snooped read
      snoop(1, 4, 0, 0, "R8 exclusive snooped");
      // R5: write to shared clean with shared response
      cpu_op(1, mk(1,0,1), 16'hA1A1, 1, "R5 write shared clean");
      snoop(1, 4, 0, 0, "R8 owner flush stays");
      snoop(1, 4, 0, 0, "R8 owner flush again");
      // R7: snooped update demotes owner
      snoop(2, 4, 3, 16'h7777, "R7 update");
      snoop(1, 4, 0, 0, "R7 no flush after update");
      cpu_op(0, mk(1,0,3), 0, 0, "R7 updated word read");
      // R5: write to shared clean, no sharers left
      cpu_op(1, mk(1,0,0), 16'hB2B2, 0, "R5 write goes modified");
      cpu_op(1, mk(1,0,0), 16'hB3B3, 0, "R4 write modified silent");
      // R4: exclusive write is silent, then snoop shows ownership
      cpu_op(0, mk(2,1,0), 0, 0, "R4 fill exclusive");
      cpu_op(1, mk(2,1,2), 16'hC4C4, 0, "R4 write exclusive");
      snoop(1, 2*4+1, 0, 0, "R8 modified flush");
      // R5: write to shared owned
      cpu_op(1, mk(2,1,3), 16'hD5D5, 1, "R5 write shared owned");
      snoop(1, 2*4+1, 0, 0, "R9 owned still shared");
      // R6: write misses
      cpu_op(1, mk(3,2,1), 16'hE6E6, 1, "R6 write miss shared");
      snoop(1, 3*4+2, 0, 0, "R6 owned after miss");
      cpu_op(1, mk(4,3,2), 16'hF7F7, 0, "R6 write miss private");
      cpu_op(1, mk(4,3,3), 16'h0808, 0, "R6 modified silent");
      // R10: evictions
      cpu_op(0, mk(5,3,0), 0, 0, "R10 evict modified");
      cpu_op(0, mk(6,3,1), 0, 0, "R10 evict clean");
      cpu_op(0, mk(7,1,0), 0, 1, "R10 evict shared owned");
      cpu_op(0, mk(2,1,3), 0, 0, "R10 written back data");
      snoop(2, 9*4+3, 0, 16'h1234, "R9 miss not shared");
      // R11: request together with a snoop waits one cycle
      @(negedge clk);
      cpu_req = 1; cpu_we = 0; cpu_addr = ADDR_W'(mk(6,3,1));
      snp_valid = 1; snp_cmd = 2'd2; snp_blk = BLK_W'(9*4+0); snp_word = 16'h5555;
      @(negedge clk);
      chk(!cpu_done, "R11 no accept during snoop", cpu_done, 0);
      snp_valid = 0;
      @(negedge clk);
      chk(cpu_done, "R11 accepted after snoop", cpu_done, 1);
      chk(cpu_rdata == mem_get(6*4+3)[1*DW +: DW], "R11 rdata", cpu_rdata, mem_get(6*4+3)[1*DW +: DW]);
      cpu_req = 0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule